// File: doc/BRIEF.md
# Dual-Mask Interrupt Aggregator

This block collects 24 single-cycle event pulses from power-management sources into three 8-bit status banks. It drives one shared active-high interrupt line toward the host. Event n is held in bank n/8 at bit n%8. Four of the events are fixed by the surrounding chip:

- bank A bit 3 is the clock alarm;
- bank A bit 4 is the periodic clock tick;
- bank B bit 0 is the watchdog;
- bank C bit 3 is USB supply detection.

Each source has two independent mask bits:

- The capture mask decides whether an event is stored in the status bit at all. A set capture mask also keeps that source off the line.
- The line mask only decides whether a stored status bit reaches the interrupt line.

Software uses a small synchronous register port: address, write data, write strobe, and combinational read data. Through it software reads the status, clears bits by writing ones, and programs both mask banks.

Top module: `pmu_irq_collect`

## Requirements
- R1: After reset all status bits read 0, all line-mask bits read 1, all capture-mask bits read 0, and `irq_o` is 0.
- R2: Event input n maps to status bank n/8, bit n%8. The address map is:
  - status banks A, B and C at 0x0, 0x1 and 0x2;
  - line-mask banks A, B and C at 0x4, 0x5 and 0x6;
  - capture-mask banks A, B and C at 0x8, 0x9 and 0xA.
- R3: An event on a source whose capture-mask bit is 0 sets its status bit at the next clock edge, whatever its line-mask bit.
- R4: An event on a source whose capture-mask bit is 1 leaves its status bit unchanged.
- R5: A source whose capture-mask bit is 1 never asserts `irq_o`, even if its status bit is set and its line-mask bit is 0.
- R6: `irq_o` is 1 exactly when some source has status 1, line mask 0 and capture mask 0.
- R7: `irq_o` is registered: it reflects the status and mask contents one clock after they change.
- R8: Writing a status address clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: When an event and a clear of the same status bit fall in the same cycle, the bit ends set.
- R10: Reads of unused addresses (0x3, 0x7, 0xB to 0xF) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 24 | Single-cycle event pulses, one per source |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Single events walked onto chosen sources show that each input lands in its own bank and bit, with no effect on neighbouring bits. Paired settings of the two masks on one source separate the three cases: not recorded, recorded but silent, and recorded and signalled. A source whose capture mask is set after its status is stored shows that the capture mask alone silences the line. Same-cycle event-and-clear and writes to unused addresses probe the edges of the write path. A long stretch of random events, writes and addresses is then compared cycle by cycle against a behavioural model, which covers mask and clear interleavings the directed steps miss.

// File: rtl/pmu_irq_pkg.sv
package pmu_irq_pkg;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int STAT_BASE  = 0;
  localparam int LMASK_BASE = 4;
  localparam int SMASK_BASE = 8;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_STAT  = 2'd1,
    KIND_LMASK = 2'd2,
    KIND_SMASK = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/pmu_irq_decode.sv
module pmu_irq_decode
  import pmu_irq_pkg::*;
#(
  parameter int NBANK  = NUM_BANKS,
  parameter int AW     = ADDR_W,
  parameter int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  parameter int S_BASE = STAT_BASE,
  parameter int L_BASE = LMASK_BASE,
  parameter int M_BASE = SMASK_BASE
) (
  input  logic [AW-1:0]     addr_i,
  output reg_kind_e         kind_o,
  output logic [BIDX_W-1:0] bank_o
);
  logic [AW-1:0] off_s, off_l, off_m;

  assign off_s = addr_i - AW'(S_BASE);
  assign off_l = addr_i - AW'(L_BASE);
  assign off_m = addr_i - AW'(M_BASE);

  always_comb begin
    kind_o = KIND_NONE;
    bank_o = '0;
    if (addr_i >= AW'(S_BASE) && off_s < AW'(NBANK)) begin
      kind_o = KIND_STAT;
      bank_o = off_s[BIDX_W-1:0];
    end else if (addr_i >= AW'(L_BASE) && off_l < AW'(NBANK)) begin
      kind_o = KIND_LMASK;
      bank_o = off_l[BIDX_W-1:0];
    end else if (addr_i >= AW'(M_BASE) && off_m < AW'(NBANK)) begin
      kind_o = KIND_SMASK;
      bank_o = off_m[BIDX_W-1:0];
    end
  end
endmodule

// File: rtl/pmu_irq_bank.sv
module pmu_irq_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         stat_we_i,
  input  logic         lmask_we_i,
  input  logic         smask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] lmask_o,
  output logic [W-1:0] smask_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, lmask_q, smask_q;
  logic [W-1:0] capt, clr;

  assign capt = evt_i & ~smask_q;
  assign clr  = stat_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      lmask_q <= '1;
      smask_q <= '0;
    end else begin
      // capture after clear: event wins
      stat_q <= (stat_q & ~clr) | capt;
      if (lmask_we_i) lmask_q <= wdata_i;
      if (smask_we_i) smask_q <= wdata_i;
    end
  end

  assign stat_o  = stat_q;
  assign lmask_o = lmask_q;
  assign smask_o = smask_q;
  assign pend_o  = |(stat_q & ~lmask_q & ~smask_q);

  // R3
  capture_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & ~smask_q)) |=> ((stat_q & $past(evt_i & ~smask_q)) == $past(evt_i & ~smask_q)));
  // R4
  masked_not_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i & ~smask_q)) == '0));
  // R8
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> ((stat_q & $past(wdata_i & ~evt_i)) == '0));
  // R9
  evt_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && |(evt_i & wdata_i & ~smask_q)) |=> ((stat_q & $past(evt_i & wdata_i & ~smask_q)) != '0));
endmodule

// File: rtl/pmu_irq_collect.sv
module pmu_irq_collect
  import pmu_irq_pkg::*;
#(
  parameter int NBANK  = NUM_BANKS,
  parameter int BW     = BANK_W,
  parameter int AW     = ADDR_W,
  parameter int NSRC   = NBANK * BW,
  parameter int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [BW-1:0]   wdata_i,
  output logic [BW-1:0]   rdata_o,
  output logic            irq_o
);
  reg_kind_e         kind;
  logic [BIDX_W-1:0] bsel;
  logic [BW-1:0]     stat_b  [NBANK];
  logic [BW-1:0]     lmask_b [NBANK];
  logic [BW-1:0]     smask_b [NBANK];
  logic [NBANK-1:0]  pend_b;
  logic [NBANK-1:0]  stat_any_b;
  logic              irq_q;

  pmu_irq_decode #(.NBANK(NBANK), .AW(AW), .BIDX_W(BIDX_W)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .bank_o (bsel)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = we_i && (bsel == BIDX_W'(b));

    pmu_irq_bank #(.W(BW)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[b*BW +: BW]),
      .stat_we_i  (hit && kind == KIND_STAT),
      .lmask_we_i (hit && kind == KIND_LMASK),
      .smask_we_i (hit && kind == KIND_SMASK),
      .wdata_i    (wdata_i),
      .stat_o     (stat_b[b]),
      .lmask_o    (lmask_b[b]),
      .smask_o    (smask_b[b]),
      .pend_o     (pend_b[b])
    );
    assign stat_any_b[b] = |stat_b[b];
  end

  always_comb begin
    rdata_o = '0;
    unique case (kind)
      KIND_STAT:  rdata_o = stat_b[bsel];
      KIND_LMASK: rdata_o = lmask_b[bsel];
      KIND_SMASK: rdata_o = smask_b[bsel];
      default:    rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_b;
  end
  assign irq_o = irq_q;

  // R6
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|stat_any_b));
  // R10
  unused_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == KIND_NONE) |-> (rdata_o == '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !irq_o);
endmodule

// File: tb/pmu_irq_collect_tb.sv
module pmu_irq_collect_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [23:0] evt;
  logic        we;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  logic [7:0] m_st [3];
  logic [7:0] m_lm [3];
  logic [7:0] m_sm [3];
  logic       m_irq;

  always #4 clk = ~clk;

  pmu_irq_collect dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  function automatic logic [7:0] m_read(logic [3:0] a);
    int ai = int'(a);
    if (ai < 3) return m_st[ai];
    if (ai >= 4 && ai < 7) return m_lm[ai-4];
    if (ai >= 8 && ai < 11) return m_sm[ai-8];
    return 8'h00;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 3; b++) begin
        m_st[b] = 8'h00; m_lm[b] = 8'hFF; m_sm[b] = 8'h00;
      end
      m_irq = 1'b0;
    end else begin
      logic nirq;
      nirq = 1'b0;
      for (int b = 0; b < 3; b++)
        if ((m_st[b] & ~m_lm[b] & ~m_sm[b]) != 8'h00) nirq = 1'b1;
      for (int b = 0; b < 3; b++) begin
        logic [7:0] clr;
        clr = (we && int'(addr) == b) ? wdata : 8'h00;
        m_st[b] = (m_st[b] & ~clr) | (evt[b*8 +: 8] & ~m_sm[b]);
        if (we && int'(addr) == 4 + b) m_lm[b] = wdata;
        if (we && int'(addr) == 8 + b) m_sm[b] = wdata;
      end
      m_irq = nirq;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      n_cmp++;
      if (rdata !== m_read(addr) || irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s model: addr=%0h rdata=%02h exp=%02h irq=%0b exp=%0b",
                 cur_req, addr, rdata, m_read(addr), irq, m_irq);
      end
    end
  end

  task automatic drive(logic [23:0] e, logic w, logic [3:0] a, logic [7:0] d);
    @(negedge clk); #1;
    evt = e; we = w; addr = a; wdata = d;
  endtask

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", r, act, exp);
    end
  endtask

  // read one address after an idle cycle
  task automatic rd(string r, logic [3:0] a, logic [7:0] exp);
    drive(24'h0, 1'b0, a, 8'h00);
    @(negedge clk);
    check(r, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; evt = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1", {7'h0, irq}, 8'h00);
    #1 rst_ni = 1'b1;

    // R1 reset contents, R10 unused zero
    cur_req = "R1";
    for (int a = 0; a < 12; a++) begin
      logic [7:0] e;
      e = (a >= 4 && a < 7) ? 8'hFF : 8'h00;
      rd((a == 3 || a == 7 || a == 11) ? "R10" : "R1", 4'(a), e);
    end

    // R2 / R3: source 13 -> bank B bit 5, line masked
    cur_req = "R3";
    drive(24'h1 << 13, 1'b0, 4'h0, 8'h00);
    rd("R2", 4'h1, 8'h20);
    rd("R3", 4'h0, 8'h00);
    check("R3", {7'h0, irq}, 8'h00);

    // R8: zeros leave bits, ones clear
    cur_req = "R8";
    drive(24'h0, 1'b1, 4'h1, 8'hDF);
    rd("R8", 4'h1, 8'h20);
    drive(24'h0, 1'b1, 4'h1, 8'h20);
    rd("R8", 4'h1, 8'h00);

    // R6 / R7: clock alarm bank A bit 3
    cur_req = "R7";
    drive(24'h1 << 3, 1'b0, 4'h0, 8'h00);
    drive(24'h0, 1'b1, 4'h4, 8'hF7);
    drive(24'h0, 1'b0, 4'h0, 8'h00);
    check("R7", {7'h0, irq}, 8'h00);
    @(negedge clk);
    check("R6", {7'h0, irq}, 8'h01);
    drive(24'h0, 1'b1, 4'h4, 8'hFF);
    drive(24'h0, 1'b1, 4'h0, 8'h08);
    rd("R6", 4'h0, 8'h00);
    check("R6", {7'h0, irq}, 8'h00);

    // R4: capture mask on USB supply bit (C3), line open
    cur_req = "R4";
    drive(24'h0, 1'b1, 4'hA, 8'h08);
    drive(24'h0, 1'b1, 4'h6, 8'h00);
    drive(24'h1 << 19, 1'b0, 4'h2, 8'h00);
    rd("R4", 4'h2, 8'h00);
    check("R4", {7'h0, irq}, 8'h00);

    // R5: stored status silenced by capture mask
    cur_req = "R5";
    drive(24'h0, 1'b1, 4'hA, 8'h00);
    drive(24'h1 << 19, 1'b0, 4'h2, 8'h00);
    rd("R3", 4'h2, 8'h08);
    check("R6", {7'h0, irq}, 8'h01);
    drive(24'h0, 1'b1, 4'hA, 8'h08);
    rd("R5", 4'h2, 8'h08);
    @(negedge clk);
    check("R5", {7'h0, irq}, 8'h00);

    // R9: event and clear together
    cur_req = "R9";
    drive(24'h0, 1'b1, 4'hA, 8'h00);
    drive(24'h1 << 19, 1'b1, 4'h2, 8'h08);
    rd("R9", 4'h2, 8'h08);

    // R10: writes to unused addresses
    cur_req = "R10";
    drive(24'h0, 1'b1, 4'h3, 8'hFF);
    drive(24'h0, 1'b1, 4'hF, 8'hFF);
    drive(24'h0, 1'b1, 4'h7, 8'h00);
    rd("R10", 4'h3, 8'h00);
    rd("R10", 4'h6, 8'h00);
    rd("R10", 4'h4, 8'hFF);

    // random interleavings, compared against the model every clock
    cur_req = "R3/R4/R5/R6/R8/R9 random";
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] e;
      e = 24'($urandom) & 24'($urandom) & 24'($urandom);
      drive(e, ($urandom % 3) == 0, 4'($urandom % 16), 8'($urandom));
    end
    drive(24'h0, 1'b0, 4'h0, 8'h00);
    repeat (2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule